// File: doc/BRIEF.md
# Triple-Buffer Page-Flip Slot Manager

This block keeps track of three frame buffer slots that a renderer and a display scan-out engine share. At any time one slot is the front slot being scanned out, one is the render slot being drawn, and the third is either a finished frame waiting to be shown or a spare. When the renderer reports a finished frame, the block hands it a free slot on the very next cycle, so drawing never stalls for vertical sync. If a second frame finishes before the display takes the first, the newer frame replaces the older one and the older slot goes back to the renderer.

At each vertical blanking strobe the newest finished frame, if there is one, becomes the front slot. The flip loads a scan-out base register with that slot's address; no pixel data moves. A slot's address is a programmable base plus the slot index times a programmable frame stride. If no frame is waiting at blanking, the current front slot is shown again.

Top module: `flip_slot_mgr`

## Requirements
- R1: After reset the front slot is 0, the render slot is 1, the third slot (2) is reported on pendingSlot, pendingValid is 0 and scanAddr is 0.
- R2: The front, render and pending slot indices are each in the range 0 to 2 and are all different in every cycle.
- R3: A renderDone pulse with no frame waiting makes the old render slot the pending slot, sets pendingValid, and gives the renderer the spare slot, all visible the cycle after the pulse.
- R4: A renderDone pulse while a frame is already waiting makes the old render slot pending and returns the older pending slot to the renderer; pendingValid stays 1.
- R5: A vblank strobe with a frame waiting (and no renderDone) makes the pending slot the front slot, reports the old front slot on pendingSlot as the spare, and clears pendingValid.
- R6: A vblank strobe with no frame waiting leaves the front slot unchanged, so the previous frame is shown again.
- R7: When renderDone and vblank arrive in the same cycle, the flip uses the frame that was waiting before that cycle, and the just-finished frame then becomes pending with pendingValid set.
- R8: The front slot changes only in the cycle after a vblank strobe.
- R9: On every vblank strobe scanAddr is loaded with baseAddr + frontSlot*frameStride for the front slot chosen at that strobe (sum taken modulo 2^ADDR_W); between strobes it holds even if baseAddr or frameStride change.
- R10: renderAddr always equals baseAddr + renderSlot*frameStride (modulo 2^ADDR_W) for the current inputs and render slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renderDone | input | 1 | One-cycle pulse: renderer finished the frame in the render slot |
| vblank | input | 1 | One-cycle strobe at the start of vertical blanking |
| baseAddr | input | ADDR_W | Address of slot 0 |
| frameStride | input | ADDR_W | Address distance between neighbouring slots |
| frontSlot | output | 2 | Slot currently scanned out |
| renderSlot | output | 2 | Slot the renderer draws into |
| pendingSlot | output | 2 | Waiting frame when pendingValid is 1, spare slot otherwise |
| pendingValid | output | 1 | A finished frame is waiting for the next flip |
| scanAddr | output | ADDR_W | Scan-out base register, loaded at vblank |
| renderAddr | output | ADDR_W | Base address of the render slot |

## Verification
The hardest situation to reach is a renderDone and a vblank in the same cycle, in both flavours: with a frame already waiting (a flip plus a new pending frame in one step) and without one. Directed steps create each flavour after setting up the waiting flag explicitly, and a long random run with a high strobe density keeps hitting coincidences and back-to-back completions, while the base and stride change between strobes to expose any scan register that tracks its inputs instead of holding.

// File: rtl/flip_pkg.sv
package flip_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  typedef logic [SLOT_W-1:0] slot_t;

  // Strobes from the slot control to the address path
  typedef struct packed {
    logic  loadScan;
    slot_t scanSlot;
    slot_t renderSlot;
  } addr_strobe_t;
endpackage

// File: rtl/flip_slot_ctrl.sv
module flip_slot_ctrl
  import flip_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         renderDone,
  input  logic         vblank,
  output slot_t        frontSlot,
  output slot_t        renderSlot,
  output slot_t        pendingSlot,
  output logic         pendingValid,
  output addr_strobe_t strobe
);
  slot_t frontQ, renderQ, pendQ;
  logic  validQ;
  slot_t freeSlot, nextFront, nextRender, nextPend;
  logic  nextValid, doFlip;

  // vblank is resolved first; renderDone then uses the result
  always_comb begin
    doFlip    = vblank && validQ;
    nextFront = doFlip ? pendQ : frontQ;
    freeSlot  = doFlip ? frontQ : pendQ;
    if (renderDone) begin
      nextPend   = renderQ;
      nextRender = freeSlot;
      nextValid  = 1'b1;
    end else begin
      nextPend   = freeSlot;
      nextRender = renderQ;
      nextValid  = validQ && !vblank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frontQ  <= slot_t'(0);
      renderQ <= slot_t'(1);
      pendQ   <= slot_t'(2);
      validQ  <= 1'b0;
    end else begin
      frontQ  <= nextFront;
      renderQ <= nextRender;
      pendQ   <= nextPend;
      validQ  <= nextValid;
    end
  end

  assign frontSlot    = frontQ;
  assign renderSlot   = renderQ;
  assign pendingSlot  = pendQ;
  assign pendingValid = validQ;

  assign strobe.loadScan   = vblank;
  assign strobe.scanSlot   = nextFront;
  assign strobe.renderSlot = renderQ;

  // R2
  a_r2_distinct: assert property (@(posedge clk) disable iff (!rstN)
    (frontQ != renderQ) && (frontQ != pendQ) && (renderQ != pendQ)
    && (frontQ < 2'd3) && (renderQ < 2'd3) && (pendQ < 2'd3));
  // R3
  a_r3_done_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    renderDone |=> validQ);
  // R4
  a_r4_old_pending_returned: assert property (@(posedge clk) disable iff (!rstN)
    (renderDone && !vblank) |=> (renderQ == $past(pendQ)) && (pendQ == $past(renderQ)));
  // R5
  a_r5_flip_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    (vblank && !renderDone) |=> !validQ);
  // R7
  a_r7_vblank_first: assert property (@(posedge clk) disable iff (!rstN)
    (vblank && renderDone && validQ) |=>
      (frontQ == $past(pendQ)) && (pendQ == $past(renderQ)) && (renderQ == $past(frontQ)));
  // R8
  a_r8_front_only_at_vblank: assert property (@(posedge clk) disable iff (!rstN)
    !vblank |=> $stable(frontQ));
endmodule

// File: rtl/flip_addr_path.sv
module flip_addr_path
  import flip_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  addr_strobe_t      strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] frameStride,
  output logic [ADDR_W-1:0] scanAddr,
  output logic [ADDR_W-1:0] renderAddr
);
  logic [ADDR_W-1:0] slotAddr [NUM_SLOTS];
  logic [ADDR_W-1:0] scanNext;
  logic [ADDR_W-1:0] scanQ;

  // One address per slot; the index is a constant so each is shift-and-add
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    assign slotAddr[g] = baseAddr + frameStride * IDX;
  end

  always_comb begin
    scanNext   = '0;
    renderAddr = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (strobe.scanSlot == slot_t'(i))   scanNext   = slotAddr[i];
      if (strobe.renderSlot == slot_t'(i)) renderAddr = slotAddr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                scanQ <= '0;
    else if (strobe.loadScan) scanQ <= scanNext;
  end

  assign scanAddr = scanQ;

  // R9
  a_r9_scan_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadScan |=> $stable(scanQ));
endmodule

// File: rtl/flip_slot_mgr.sv
module flip_slot_mgr
  import flip_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              renderDone,
  input  logic              vblank,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] frameStride,
  output logic [1:0]        frontSlot,
  output logic [1:0]        renderSlot,
  output logic [1:0]        pendingSlot,
  output logic              pendingValid,
  output logic [ADDR_W-1:0] scanAddr,
  output logic [ADDR_W-1:0] renderAddr
);
  addr_strobe_t strobe;

  flip_slot_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .renderDone   (renderDone),
    .vblank       (vblank),
    .frontSlot    (frontSlot),
    .renderSlot   (renderSlot),
    .pendingSlot  (pendingSlot),
    .pendingValid (pendingValid),
    .strobe       (strobe)
  );

  flip_addr_path #(.ADDR_W(ADDR_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .baseAddr    (baseAddr),
    .frameStride (frameStride),
    .scanAddr    (scanAddr),
    .renderAddr  (renderAddr)
  );
endmodule

// File: tb/flip_slot_mgr_tb.sv
module flip_slot_mgr_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          renderDone = 1'b0;
  logic          vblank = 1'b0;
  logic [AW-1:0] baseAddr = 32'h1000_0000;
  logic [AW-1:0] frameStride = 32'h0007_E900;
  logic [1:0]    frontSlot, renderSlot, pendingSlot;
  logic          pendingValid;
  logic [AW-1:0] scanAddr, renderAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  int          mFront, mRender, mPend;
  bit          mValid;
  logic [AW-1:0] mScan;

  always #2 clk = ~clk;

  flip_slot_mgr #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .renderDone(renderDone), .vblank(vblank),
    .baseAddr(baseAddr), .frameStride(frameStride),
    .frontSlot(frontSlot), .renderSlot(renderSlot), .pendingSlot(pendingSlot),
    .pendingValid(pendingValid), .scanAddr(scanAddr), .renderAddr(renderAddr)
  );

  function automatic logic [AW-1:0] expAddr(int idx);
    return baseAddr + frameStride * AW'(idx);
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " front"}, AW'(frontSlot), AW'(mFront));
    check({tag, " render"}, AW'(renderSlot), AW'(mRender));
    check({tag, " pending"}, AW'(pendingSlot), AW'(mPend));
    check({tag, " valid"}, AW'(pendingValid), AW'(mValid));
    check({tag, " R9 scanAddr"}, scanAddr, mScan);
    check({tag, " R10 renderAddr"}, renderAddr, expAddr(mRender));
    check({tag, " R2 distinct"},
          AW'(frontSlot != renderSlot && frontSlot != pendingSlot &&
              renderSlot != pendingSlot && pendingSlot != 2'd3 &&
              frontSlot != 2'd3 && renderSlot != 2'd3), AW'(1));
  endtask

  // Model: vblank handled first, then renderDone
  task automatic modelStep(bit rd, bit vb);
    int freeS, oldFront;
    oldFront = mFront;
    freeS = mPend;
    if (vb && mValid) begin
      mFront = mPend;
      freeS  = oldFront;
    end
    if (vb) mScan = expAddr(mFront);
    if (rd) begin
      mPend   = mRender;
      mRender = freeS;
      mValid  = 1;
    end else begin
      mPend  = freeS;
      mValid = mValid && !vb;
    end
  endtask

  // Called at a negedge: drive, take one edge, check at the next negedge
  task automatic step(bit rd, bit vb, string tag);
    renderDone = rd;
    vblank = vb;
    @(posedge clk);
    modelStep(rd, vb);
    @(negedge clk);
    renderDone = 0;
    vblank = 0;
    checkAll(tag);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    mFront = 0; mRender = 1; mPend = 2; mValid = 0; mScan = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll("R1 reset");

    step(0, 1, "R6 vblank no pending");
    step(1, 0, "R3 first done");
    step(1, 0, "R4 done replaces pending");
    step(0, 1, "R5 flip");
    check("R8 front after flip", AW'(frontSlot), AW'(2));
    step(0, 0, "R8 idle");
    // coincidence without a waiting frame
    step(1, 1, "R7 both, none waiting");
    // coincidence with a waiting frame
    step(1, 1, "R7 both, one waiting");
    // change base/stride between strobes: scan holds, render follows
    baseAddr = 32'h2345_6000;
    frameStride = 32'h0001_0040;
    step(0, 0, "R9 hold after base change");
    step(0, 1, "R9 reload at vblank");
    step(0, 1, "R6 repeat frame");

    for (int n = 0; n < 4000; n++) begin
      bit rd, vb;
      rd = ($urandom % 3) == 0;
      vb = ($urandom % 5) == 0;
      if (($urandom % 64) == 0) baseAddr = $urandom;
      if (($urandom % 64) == 0) frameStride = $urandom;
      step(rd, vb, "R2-random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule